// File: doc/BRIEF.md
# Indirect-Access Interrupt Redirection Register File

This block is the configuration front end of an I/O interrupt redirection controller. Software reaches it through a two-location, 32-bit memory-mapped window: one location holds an index, the other is a data port that reads or writes whichever internal register the index names. The internal registers are the following:

- a controller identity register;
- a read-only version register that also reports the table size;
- an arbitration identity register;
- a table of 64-bit redirection entries, each reached as two 32-bit halves.

Every redirection entry is driven out in parallel on a flat bus, so a separate delivery engine can decode vectors, masks and destinations without going through the window. Bad accesses raise a sticky error flag. An access is bad if it is not full width, if it uses an offset outside the window, or if it reaches an undefined index through the data port. The flag stays set until reset.

Inside each entry, lower-half bit 16 is the mask and upper-half bits 31:24 are the destination. The remaining lower-half bits 15:0 are kept, and they carry the vector, the delivery mode and the trigger settings. Lower-half bits 31:17 and upper-half bits 23:0 are reserved and always read as zero.

Top module: `irq_redir_regs`

## Requirements
- R1: The window select register sits at byte offset 0 and the data port at byte offset 16. The select register is 8 bits wide and reads back zero-extended. Each accepted read returns its data on `rd_data` with `rd_valid` high in the cycle after the access. `rd_data` holds its value when no read is made.
- R2: An access is not applied if its byte enables are not 4'hF or its offset is neither 0 nor 16. Such an access changes no state, a read of it returns zero, and it sets `err_flag`. `err_flag` stays high until reset.
- R3: Index 0x00 holds the controller identity in bits 31:24. A write changes only that field. Bits 23:0 read as zero.
- R4: Index 0x01 is read-only. It returns (entry count - 1) in bits 23:16 and the version constant in bits 7:0, with all other bits zero. This is 0x00170011 with the default parameters. Writes to it have no effect.
- R5: Index 0x02 holds the arbitration identity in bits 31:24. The field is readable and writable, and bits 23:0 read as zero.
- R6: Redirection entry n has its lower half at index 0x10+2n and its upper half at index 0x11+2n. `tbl_out[64n +: 64]` equals {upper, lower} of entry n.
- R7: A write to a lower half stores only bits 16:0 and clears bits 31:17. A write to an upper half stores only bits 31:24 and clears bits 23:0.
- R8: After reset the following hold:
  - every entry reads 0x0000_0000_0001_0000, so only the mask bit is set;
  - both the identity and the arbitration identity equal the INIT_ID parameter (default 8'h05);
  - the select register is zero;
  - `err_flag` is low.
- R9: A data-port access whose index is undefined sets `err_flag`. Undefined indices are 0x03 to 0x0F and anything from 0x10+2×entry count upward, which is 0x40 with the defaults. A read of such an index returns zero, and a write to it changes no register.
- R10: A data-port access uses the select value written in any earlier cycle, including the cycle immediately before it. A read response already issued is not altered by a later select write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| acc_valid | input | 1 | Access strobe, one access per cycle |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_addr | input | ADDR_W (5) | Byte offset within the window |
| acc_be | input | 4 | Byte enables; only 4'hF is legal |
| acc_wdata | input | 32 | Write data |
| rd_valid | output | 1 | Read response valid, one cycle after a read |
| rd_data | output | 32 | Read response data |
| err_flag | output | 1 | Sticky error for bad window accesses and undefined indices |
| tbl_out | output | NUM_ENT*64 (1536) | All redirection entries, entry n at bits 64n+63:64n |

## Verification
The overlap that matters here is the read response and a change of index. A data-port read's response is presented in the same cycle that a new select write is accepted. Likewise, a select write in one cycle is followed at once by a data read that must already see the new index. The bench drives these as back-to-back accesses with no idle cycle between them. It judges the response by comparing it against the register named by the old select and by the new select respectively. Each is compared to an entry value chosen to differ from its neighbours, so a one-cycle slip in the select path produces a wrong value rather than a plausible one.

// File: rtl/irq_redir_pkg.sv
package irq_redir_pkg;

  typedef enum logic [2:0] {
    K_IDENT = 3'd0,
    K_VERS  = 3'd1,
    K_ARBID = 3'd2,
    K_ENTRY = 3'd3,
    K_UNDEF = 3'd4
  } reg_kind_e;

  localparam logic [7:0]  IDX_IDENT = 8'h00;
  localparam logic [7:0]  IDX_VERS  = 8'h01;
  localparam logic [7:0]  IDX_ARBID = 8'h02;
  localparam logic [7:0]  IDX_BASE  = 8'h10;
  localparam int          OFS_SEL   = 0;
  localparam int          OFS_DATA  = 16;
  localparam logic [63:0] ENTRY_RST = 64'h0000_0000_0001_0000;

  // Lower half keeps mask, trigger, polarity, mode and vector (16:0).
  function automatic logic [31:0] keep_lo(input logic [31:0] w);
    return {15'b0, w[16:0]};
  endfunction

  // Upper half keeps only the destination byte.
  function automatic logic [31:0] keep_hi(input logic [31:0] w);
    return {w[31:24], 24'b0};
  endfunction

endpackage

// File: rtl/irq_redir_decode.sv
module irq_redir_decode
  import irq_redir_pkg::*;
#(
  parameter int NUM_ENT = 24,
  parameter int ADDR_W  = 5,
  parameter int IDX_W   = $clog2(NUM_ENT)
) (
  input  logic              acc_valid,
  input  logic              acc_write,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [3:0]        acc_be,
  input  logic [7:0]        sel_q,
  output logic              sel_we,
  output logic              data_we,
  output logic              sel_rd,
  output logic              data_rd,
  output logic              rd_req,
  output reg_kind_e         kind,
  output logic [IDX_W-1:0]  ent_idx,
  output logic              ent_hi,
  output logic              acc_err
);

  localparam logic [7:0] TBL_END = 8'(16 + 2 * NUM_ENT);

  logic       full_w;
  logic       at_sel;
  logic       at_data;
  logic       win_ok;
  logic [7:0] rel;

  always_comb begin
    full_w  = (acc_be == 4'hF);
    at_sel  = (acc_addr == ADDR_W'(OFS_SEL));
    at_data = (acc_addr == ADDR_W'(OFS_DATA));
    win_ok  = acc_valid && full_w && (at_sel || at_data);

    rel     = sel_q - IDX_BASE;
    ent_idx = rel[IDX_W:1];
    ent_hi  = rel[0];

    if (sel_q == IDX_IDENT)                        kind = K_IDENT;
    else if (sel_q == IDX_VERS)                    kind = K_VERS;
    else if (sel_q == IDX_ARBID)                   kind = K_ARBID;
    else if (sel_q >= IDX_BASE && sel_q < TBL_END) kind = K_ENTRY;
    else                                           kind = K_UNDEF;

    sel_we  = win_ok &&  acc_write && at_sel;
    data_we = win_ok &&  acc_write && at_data;
    sel_rd  = win_ok && !acc_write && at_sel;
    data_rd = win_ok && !acc_write && at_data;
    rd_req  = acc_valid && !acc_write;
    acc_err = acc_valid &&
              (!full_w || !(at_sel || at_data) || (at_data && kind == K_UNDEF));
  end

endmodule

// File: rtl/irq_redir_entry.sv
module irq_redir_entry
  import irq_redir_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_lo,
  input  logic        wr_hi,
  input  logic [31:0] wdata,
  output logic [63:0] entry_q
);

  logic [63:0] entry_d;
  logic        entry_en;

  always_comb begin
    entry_d  = entry_q;
    entry_en = wr_lo || wr_hi;
    if (wr_lo) entry_d[31:0]  = keep_lo(wdata);
    if (wr_hi) entry_d[63:32] = keep_hi(wdata);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        entry_q <= ENTRY_RST;
    else if (entry_en) entry_q <= entry_d;
  end

endmodule

// File: rtl/irq_redir_rdmux.sv
module irq_redir_rdmux
  import irq_redir_pkg::*;
#(
  parameter int         NUM_ENT = 24,
  parameter logic [7:0] VERSION = 8'h11,
  parameter int         IDX_W   = $clog2(NUM_ENT)
) (
  input  logic                  sel_rd,
  input  logic                  data_rd,
  input  reg_kind_e             kind,
  input  logic [IDX_W-1:0]      ent_idx,
  input  logic                  ent_hi,
  input  logic [7:0]            sel_q,
  input  logic [7:0]            id_q,
  input  logic [7:0]            arb_q,
  input  logic [NUM_ENT*64-1:0] tbl_flat,
  output logic [31:0]           rword
);

  localparam logic [31:0] VER_WORD = {8'h00, 8'(NUM_ENT - 1), 8'h00, VERSION};

  logic [63:0] ent_sel;

  always_comb begin
    ent_sel = tbl_flat[int'(ent_idx) * 64 +: 64];
    rword   = 32'h0;
    if (sel_rd) begin
      rword = {24'h0, sel_q};
    end else if (data_rd) begin
      case (kind)
        K_IDENT: rword = {id_q, 24'h0};
        K_VERS:  rword = VER_WORD;
        K_ARBID: rword = {arb_q, 24'h0};
        K_ENTRY: rword = ent_hi ? ent_sel[63:32] : ent_sel[31:0];
        default: rword = 32'h0;
      endcase
    end
  end

endmodule

// File: rtl/irq_redir_regs.sv
module irq_redir_regs
  import irq_redir_pkg::*;
#(
  parameter int         NUM_ENT = 24,
  parameter logic [7:0] INIT_ID = 8'h05,
  parameter logic [7:0] VERSION = 8'h11,
  parameter int         ADDR_W  = 5
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  acc_valid,
  input  logic                  acc_write,
  input  logic [ADDR_W-1:0]     acc_addr,
  input  logic [3:0]            acc_be,
  input  logic [31:0]           acc_wdata,
  output logic                  rd_valid,
  output logic [31:0]           rd_data,
  output logic                  err_flag,
  output logic [NUM_ENT*64-1:0] tbl_out
);

  localparam int IDX_W = $clog2(NUM_ENT);

  // reset: asynchronous assert, synchronous release
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  // decode
  logic             sel_we, data_we, sel_rd, data_rd, rd_req, acc_err;
  reg_kind_e        kind;
  logic [IDX_W-1:0] ent_idx;
  logic             ent_hi;
  logic [7:0]       sel_q, id_q, arb_q;

  irq_redir_decode #(.NUM_ENT(NUM_ENT), .ADDR_W(ADDR_W), .IDX_W(IDX_W)) dec_i (
    .acc_valid (acc_valid),
    .acc_write (acc_write),
    .acc_addr  (acc_addr),
    .acc_be    (acc_be),
    .sel_q     (sel_q),
    .sel_we    (sel_we),
    .data_we   (data_we),
    .sel_rd    (sel_rd),
    .data_rd   (data_rd),
    .rd_req    (rd_req),
    .kind      (kind),
    .ent_idx   (ent_idx),
    .ent_hi    (ent_hi),
    .acc_err   (acc_err)
  );

  // redirection table
  logic [NUM_ENT-1:0] wr_lo, wr_hi;

  for (genvar n = 0; n < NUM_ENT; n++) begin : g_ent
    assign wr_lo[n] = data_we && (kind == K_ENTRY) && (ent_idx == IDX_W'(n)) && !ent_hi;
    assign wr_hi[n] = data_we && (kind == K_ENTRY) && (ent_idx == IDX_W'(n)) &&  ent_hi;

    irq_redir_entry ent_i (
      .clk     (clk),
      .rst_n   (rst_int_n),
      .wr_lo   (wr_lo[n]),
      .wr_hi   (wr_hi[n]),
      .wdata   (acc_wdata),
      .entry_q (tbl_out[n*64 +: 64])
    );
  end

  // read path
  logic [31:0] rword;

  irq_redir_rdmux #(.NUM_ENT(NUM_ENT), .VERSION(VERSION), .IDX_W(IDX_W)) mux_i (
    .sel_rd   (sel_rd),
    .data_rd  (data_rd),
    .kind     (kind),
    .ent_idx  (ent_idx),
    .ent_hi   (ent_hi),
    .sel_q    (sel_q),
    .id_q     (id_q),
    .arb_q    (arb_q),
    .tbl_flat (tbl_out),
    .rword    (rword)
  );

  // scalar registers: next state
  logic [7:0]  sel_d, id_d, arb_d;
  logic        sel_en, id_en, arb_en, err_d;
  logic [31:0] rd_data_d;

  always_comb begin
    sel_d     = acc_wdata[7:0];
    sel_en    = sel_we;
    id_d      = acc_wdata[31:24];
    id_en     = data_we && (kind == K_IDENT);
    arb_d     = acc_wdata[31:24];
    arb_en    = data_we && (kind == K_ARBID);
    err_d     = err_flag || acc_err;
    rd_data_d = rword;
  end

  // scalar registers: state
  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      sel_q    <= 8'h00;
      id_q     <= INIT_ID;
      arb_q    <= INIT_ID;
      err_flag <= 1'b0;
      rd_valid <= 1'b0;
      rd_data  <= 32'h0;
    end else begin
      if (sel_en) sel_q   <= sel_d;
      if (id_en)  id_q    <= id_d;
      if (arb_en) arb_q   <= arb_d;
      if (rd_req) rd_data <= rd_data_d;
      err_flag <= err_d;
      rd_valid <= rd_req;
    end
  end

endmodule

// File: rtl/irq_redir_chk.sv
module irq_redir_chk #(
  parameter int         NUM_ENT = 24,
  parameter logic [7:0] VERSION = 8'h11,
  parameter int         ADDR_W  = 5
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  acc_valid,
  input logic                  acc_write,
  input logic [ADDR_W-1:0]     acc_addr,
  input logic [3:0]            acc_be,
  input logic [7:0]            sel_q,
  input logic                  rd_valid,
  input logic [31:0]           rd_data,
  input logic                  err_flag,
  input logic [NUM_ENT*64-1:0] tbl_out
);

  localparam logic [31:0] VER_WORD = {8'h00, 8'(NUM_ENT - 1), 8'h00, VERSION};
  localparam logic [7:0]  TBL_END  = 8'(16 + 2 * NUM_ENT);

  logic data_ok;
  assign data_ok = acc_valid && acc_be == 4'hF && acc_addr == ADDR_W'(16);

  a_r1_rd_valid: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && !acc_write) |=> rd_valid);

  a_r1_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !(acc_valid && !acc_write) |=> !rd_valid);

  a_r2_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    err_flag |=> err_flag);

  a_r2_bad_ofs: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && !acc_write && acc_addr != ADDR_W'(0) && acc_addr != ADDR_W'(16))
      |=> (err_flag && rd_data == 32'h0));

  a_r3_id_low_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (data_ok && !acc_write && sel_q == 8'h00) |=> rd_data[23:0] == 24'h0);

  a_r4_version: assert property (@(posedge clk) disable iff (!rst_n)
    (data_ok && !acc_write && sel_q == 8'h01) |=> rd_data == VER_WORD);

  a_r9_undef_write: assert property (@(posedge clk) disable iff (!rst_n)
    (data_ok && acc_write && sel_q >= TBL_END) |=> ($stable(tbl_out) && err_flag));

  for (genvar n = 0; n < NUM_ENT; n++) begin : g_rsv
    a_r7_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (tbl_out[n*64+17 +: 15] == 15'h0) && (tbl_out[n*64+32 +: 24] == 24'h0));
  end

endmodule

bind irq_redir_regs irq_redir_chk #(
  .NUM_ENT(NUM_ENT), .VERSION(VERSION), .ADDR_W(ADDR_W)
) chk_i (
  .clk       (clk),
  .rst_n     (rst_int_n),
  .acc_valid (acc_valid),
  .acc_write (acc_write),
  .acc_addr  (acc_addr),
  .acc_be    (acc_be),
  .sel_q     (sel_q),
  .rd_valid  (rd_valid),
  .rd_data   (rd_data),
  .err_flag  (err_flag),
  .tbl_out   (tbl_out)
);

// File: tb/irq_redir_regs_tb.sv
module irq_redir_regs_tb_top;

  localparam int NUM = 24;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              acc_valid, acc_write;
  logic [4:0]        acc_addr;
  logic [3:0]        acc_be;
  logic [31:0]       acc_wdata;
  logic              rd_valid;
  logic [31:0]       rd_data;
  logic              err_flag;
  logic [NUM*64-1:0] tbl_out;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [63:0] exp_tbl [NUM];

  irq_redir_regs dut_i (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
    .acc_addr(acc_addr), .acc_be(acc_be), .acc_wdata(acc_wdata),
    .rd_valid(rd_valid), .rd_data(rd_data), .err_flag(err_flag), .tbl_out(tbl_out)
  );

  always #10 clk = ~clk;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic chk_tbl(input string req);
    for (int n = 0; n < NUM; n++) chk(req, tbl_out[n*64 +: 64], exp_tbl[n]);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; acc_valid = 1'b0; acc_write = 1'b0;
    acc_addr = '0; acc_be = 4'hF; acc_wdata = '0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    for (int n = 0; n < NUM; n++) exp_tbl[n] = 64'h0000_0000_0001_0000;
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d, input logic [3:0] be = 4'hF);
    @(negedge clk);
    acc_valid = 1'b1; acc_write = 1'b1; acc_addr = a; acc_be = be; acc_wdata = d;
    @(negedge clk);
    acc_valid = 1'b0; acc_write = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d, input logic [3:0] be = 4'hF);
    @(negedge clk);
    acc_valid = 1'b1; acc_write = 1'b0; acc_addr = a; acc_be = be;
    @(negedge clk);
    acc_valid = 1'b0;
    d = rd_data;
    chk("R1 rd_valid", {63'b0, rd_valid}, 64'd1);
  endtask

  task automatic rd_idx(input logic [7:0] idx, output logic [31:0] d);
    wr(5'd0, {24'h0, idx});
    rd(5'd16, d);
  endtask

  task automatic wr_idx(input logic [7:0] idx, input logic [31:0] v);
    wr(5'd0, {24'h0, idx});
    wr(5'd16, v);
  endtask

  task automatic t_reset_state();
    logic [31:0] d;
    chk("R8 err low", {63'b0, err_flag}, 64'd0);
    chk_tbl("R8 table reset");
    rd(5'd0, d);        chk("R8 select zero", {32'b0, d}, 64'h0);
    rd(5'd16, d);       chk("R8 ident init", {32'b0, d}, 64'h0500_0000);
    rd_idx(8'h02, d);   chk("R8 arb init", {32'b0, d}, 64'h0500_0000);
    rd_idx(8'h10, d);   chk("R8 entry0 lo", {32'b0, d}, 64'h0001_0000);
    rd_idx(8'h3F, d);   chk("R8 entry23 hi", {32'b0, d}, 64'h0);
  endtask

  task automatic t_select();
    logic [31:0] d;
    wr(5'd0, 32'hFFFF_FF2A);
    rd(5'd0, d);
    chk("R1 select 8-bit readback", {32'b0, d}, 64'h2A);
    @(negedge clk);
    chk("R1 rd_valid low when idle", {63'b0, rd_valid}, 64'd0);
  endtask

  task automatic t_ident_arb();
    logic [31:0] d;
    wr_idx(8'h00, 32'hA5FF_FFFF);
    rd(5'd16, d);      chk("R3 ident field only", {32'b0, d}, 64'hA500_0000);
    wr_idx(8'h02, 32'h3C12_3456);
    rd(5'd16, d);      chk("R5 arb field", {32'b0, d}, 64'h3C00_0000);
    rd_idx(8'h00, d);  chk("R5 ident unaffected", {32'b0, d}, 64'hA500_0000);
  endtask

  task automatic t_version();
    logic [31:0] d;
    rd_idx(8'h01, d);  chk("R4 version word", {32'b0, d}, 64'h0017_0011);
    wr(5'd16, 32'hFFFF_FFFF);
    rd(5'd16, d);      chk("R4 read-only", {32'b0, d}, 64'h0017_0011);
    chk_tbl("R4 table untouched");
  endtask

  task automatic t_entries();
    logic [31:0] d;
    wr_idx(8'h1A, 32'hFFFF_FFFF);  // entry 5 lo
    exp_tbl[5][31:0] = 32'h0001_FFFF;
    rd(5'd16, d);      chk("R7 lo reserved cleared", {32'b0, d}, 64'h0001_FFFF);
    wr_idx(8'h1B, 32'hFFFF_FFFF);  // entry 5 hi
    exp_tbl[5][63:32] = 32'hFF00_0000;
    rd(5'd16, d);      chk("R7 hi reserved cleared", {32'b0, d}, 64'hFF00_0000);
    wr_idx(8'h3E, 32'h0000_00AB);  // entry 23 lo, unmask
    exp_tbl[23][31:0] = 32'h0000_00AB;
    wr_idx(8'h3F, 32'h8000_0000);  // entry 23 hi
    exp_tbl[23][63:32] = 32'h8000_0000;
    wr_idx(8'h12, 32'h0000_1234);  // entry 1 lo
    exp_tbl[1][31:0] = 32'h0000_1234;
    @(negedge clk);
    chk_tbl("R6 table layout");
  endtask

  task automatic t_back_to_back();
    logic [31:0] d;
    // select write followed at once by data read
    @(negedge clk);
    acc_valid = 1'b1; acc_write = 1'b1; acc_addr = 5'd0; acc_wdata = 32'h12; acc_be = 4'hF;
    @(negedge clk);
    acc_write = 1'b0; acc_addr = 5'd16;
    @(negedge clk);
    chk("R10 read uses new select", {32'b0, rd_data}, 64'h0000_1234);
    // data read followed at once by select write
    acc_write = 1'b0; acc_addr = 5'd16;
    @(negedge clk);
    d = rd_data;
    chk("R10 response from old select", {32'b0, d}, 64'h0000_1234);
    acc_write = 1'b1; acc_addr = 5'd0; acc_wdata = 32'h1A;
    @(negedge clk);
    acc_valid = 1'b0; acc_write = 1'b0;
    chk("R10 response held across select write", {32'b0, rd_data}, 64'h0000_1234);
    rd(5'd16, d);
    chk("R10 next read uses new select", {32'b0, d}, 64'h0001_FFFF);
  endtask

  task automatic t_undefined_index();
    logic [31:0] d;
    chk("R9 err low before", {63'b0, err_flag}, 64'd0);
    wr_idx(8'h40, 32'hFFFF_FFFF);
    chk("R9 err after undefined write", {63'b0, err_flag}, 64'd1);
    chk_tbl("R9 write ignored");
    rd(5'd16, d);      chk("R9 undefined read zero", {32'b0, d}, 64'h0);
    rd_idx(8'h03, d);  chk("R9 gap read zero", {32'b0, d}, 64'h0);
    rd_idx(8'h00, d);  chk("R9 ident intact", {32'b0, d}, 64'hA500_0000);
  endtask

  task automatic t_bad_window();
    logic [31:0] d;
    do_reset();
    chk("R2 err clear after reset", {63'b0, err_flag}, 64'd0);
    wr(5'd0, 32'h0000_0010, 4'h3);
    chk("R2 err after partial write", {63'b0, err_flag}, 64'd1);
    rd(5'd0, d);       chk("R2 partial write ignored", {32'b0, d}, 64'h0);
    rd(5'd4, d);       chk("R2 bad offset read zero", {32'b0, d}, 64'h0);
    wr(5'd8, 32'hFFFF_FFFF);
    chk_tbl("R2 bad offset write ignored");
    repeat (3) @(negedge clk);
    chk("R2 err sticky", {63'b0, err_flag}, 64'd1);
  endtask

  initial begin
    do_reset();
    t_reset_state();
    t_select();
    t_ident_arb();
    t_version();
    t_entries();
    t_back_to_back();
    t_undefined_index();
    t_bad_window();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule